// File: doc/BRIEF.md
# Network Controller Command and Interrupt Status Registers

This block holds the command register, the interrupt status register and the interrupt mask of a page-buffered Ethernet controller, and drives the interrupt request line. A host reaches it through a simple byte-wide register port. A write to the command register can start or stop the controller, launch a remote DMA transfer in either direction, or launch transmission of a frame held in the packet buffer.

Events from the remote DMA engine, the transmit path and the receive side set bits in the status register. The host clears those bits by writing ones to them. The reset-status bit is the one exception: it is set only by reset and cleared only by a start command.

The packet buffer, the MAC and the frame transmission itself are outside this block. A transmit launch appears here as a one-cycle strobe, together with the frame's start address and length. Transmit completion comes back as a one-cycle input.

Register map (byte offsets on `regAddr`): 0 command, 1 status (write ones to clear), 2 mask, 3 transmit page, 4 transmit length low byte, 5 transmit length high byte, 6 transmit status (read-only).

Top module: `nic_cmd_status`

## Requirements
- R1: While `rstN` is low and after it is released, the status register reads 0x80, the command register 0x01, and the mask, transmit page, both length bytes and transmit status read 0x00. `irq`, `running`, `txStart`, `remRdStart` and `remWrStart` are 0.
- R2: Status bit 7 (reset flag) is cleared by a write to offset 0 with bit 1 (start) set. A write to offset 1 never clears it. Nothing but reset sets it.
- R3: A write to offset 1 clears each of status bits 6..0 for which the written byte holds a 1. If an event sets the same bit in the same cycle, the set wins.
- R4: A command write with start (bit 1) and remote read (bit 3) or remote write (bit 4) set, while `remCountZero` is 1, sets status bit 6 one cycle later and gives no remote start pulse.
- R5: A command write with start and exactly one of remote read or remote write set, while `remCountZero` is 0, gives a one-cycle `remRdStart` or `remWrStart` pulse in the next cycle. If both are set, neither pulse occurs.
- R6: A command write with start and transmit (bit 2) set gives a one-cycle `txStart` pulse in the next cycle. At that point `txStartAddr` equals the transmit page times 256 and `txLen` equals {high byte, low byte}. Transmit without start gives no pulse.
- R7: A `txDone` pulse sets status bit 1 and loads the transmit status with 0x01, with bit 6 taken from `txHbLost` and bit 7 from `txLateColl`.
- R8: A `dmaDone` pulse sets status bit 6, and `evtSet[i]` sets status bit i for i in 0..6.
- R9: `irq` is 1 exactly when the status register AND the mask is nonzero. It follows any change of either register in the same cycle that change becomes visible.
- R10: `running` is set by a command write with start and cleared by one with stop (bit 0). When both are set, stop wins.
- R11: Reads are side-effect free and return the register at the offset. Offset 6 ignores writes, and offset 7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` (combinational) |
| remCountZero | input | 1 | Remote byte count is zero |
| dmaDone | input | 1 | Remote DMA completion pulse |
| txDone | input | 1 | Transmission completion pulse |
| txHbLost | input | 1 | Collision heartbeat lost, valid with `txDone` |
| txLateColl | input | 1 | Out-of-window collision, valid with `txDone` |
| evtSet | input | 7 | Per-bit status set requests for bits 6..0 |
| irq | output | 1 | Interrupt request |
| running | output | 1 | Controller started |
| txStart | output | 1 | Transmit launch strobe |
| txStartAddr | output | 16 | Frame start address in the buffer |
| txLen | output | 16 | Frame length in bytes |
| remRdStart | output | 1 | Remote read launch strobe |
| remWrStart | output | 1 | Remote write launch strobe |

## Verification
Every register update and every launch strobe is due exactly one clock after the edge that samples the write or event. `irq` and `regRdata` are combinational from the registers, so they are valid in that same cycle. The bench applies each stimulus at a falling edge and holds it across one rising edge. At the next falling edge it compares the strobes, `irq`, `running` and the transmit address and length against its model. It then reads registers back with the write strobe low, changing only `regAddr` between reads, so no read disturbs state.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;
  localparam int DW = 8;

  // register offsets
  localparam int REG_CMD   = 0;
  localparam int REG_STAT  = 1;
  localparam int REG_MASK  = 2;
  localparam int REG_PAGE  = 3;
  localparam int REG_LENLO = 4;
  localparam int REG_LENHI = 5;
  localparam int REG_TSTAT = 6;

  // command bit positions
  localparam int CMD_STOP  = 0;
  localparam int CMD_START = 1;
  localparam int CMD_TX    = 2;
  localparam int CMD_RRD   = 3;
  localparam int CMD_RWR   = 4;

  // status bit positions
  localparam int ST_PTX = 1;
  localparam int ST_RDC = 6;
  localparam int ST_RST = 7;

  localparam logic [DW-1:0] CMD_RESET_VAL  = 8'h01;
  localparam logic [DW-1:0] STAT_RESET_VAL = 8'h80;

  typedef struct packed {
    logic          cmdWr;
    logic          maskWr;
    logic          pageWr;
    logic          lenLoWr;
    logic          lenHiWr;
    logic          isrClr;
    logic [DW-2:0] clrBits;
    logic          startReq;
    logic          stopReq;
    logic          txGo;
    logic          remRdGo;
    logic          remWrGo;
    logic          remZero;
  } ctrlStrobes_t;
endpackage

// File: rtl/nic_cmd_decode.sv
module nic_cmd_decode
  import nic_cmd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DW-1:0]     regWdata,
  input  logic              remCountZero,
  output ctrlStrobes_t      st
);
  logic hitCmd, hitStat, hitMask, hitPage, hitLo, hitHi;
  logic rdReq, wrReq;

  assign hitCmd  = regWe && (regAddr == ADDR_W'(REG_CMD));
  assign hitStat = regWe && (regAddr == ADDR_W'(REG_STAT));
  assign hitMask = regWe && (regAddr == ADDR_W'(REG_MASK));
  assign hitPage = regWe && (regAddr == ADDR_W'(REG_PAGE));
  assign hitLo   = regWe && (regAddr == ADDR_W'(REG_LENLO));
  assign hitHi   = regWe && (regAddr == ADDR_W'(REG_LENHI));

  always_comb begin
    st          = '0;
    st.cmdWr    = hitCmd;
    st.maskWr   = hitMask;
    st.pageWr   = hitPage;
    st.lenLoWr  = hitLo;
    st.lenHiWr  = hitHi;
    st.isrClr   = hitStat;
    st.clrBits  = regWdata[DW-2:0];
    st.startReq = hitCmd && regWdata[CMD_START];
    st.stopReq  = hitCmd && regWdata[CMD_STOP];
    rdReq       = st.startReq && regWdata[CMD_RRD];
    wrReq       = st.startReq && regWdata[CMD_RWR];
    st.txGo     = st.startReq && regWdata[CMD_TX];
    st.remZero  = (rdReq || wrReq) && remCountZero;
    st.remRdGo  = rdReq && !wrReq && !remCountZero;
    st.remWrGo  = wrReq && !rdReq && !remCountZero;
  end
endmodule

// File: rtl/nic_cmd_regs.sv
module nic_cmd_regs
  import nic_cmd_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int PAGE_SHIFT = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               st,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [DW-1:0]              regWdata,
  input  logic                       dmaDone,
  input  logic                       txDone,
  input  logic                       txHbLost,
  input  logic                       txLateColl,
  input  logic [DW-2:0]              evtSet,
  output logic [DW-1:0]              regRdata,
  output logic                       irq,
  output logic                       running,
  output logic                       txStart,
  output logic [DW+PAGE_SHIFT-1:0]   txStartAddr,
  output logic [2*DW-1:0]            txLen,
  output logic                       remRdStart,
  output logic                       remWrStart
);
  logic [DW-1:0] cmdQ, isrQ, isrNext, imrQ, pageQ, lenLoQ, lenHiQ, txStatQ;

  // per-bit status update: set beats host clear
  for (genvar gi = 0; gi < DW - 1; gi++) begin : g_isrBit
    localparam bit IS_PTX = (gi == ST_PTX);
    localparam bit IS_RDC = (gi == ST_RDC);
    logic setB;
    assign setB = evtSet[gi]
                | (IS_PTX && txDone)
                | (IS_RDC && (dmaDone || st.remZero));
    assign isrNext[gi] = setB | (isrQ[gi] & ~(st.isrClr & st.clrBits[gi]));
  end
  assign isrNext[ST_RST] = isrQ[ST_RST] & ~st.startReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ       <= CMD_RESET_VAL;
      isrQ       <= STAT_RESET_VAL;
      imrQ       <= '0;
      pageQ      <= '0;
      lenLoQ     <= '0;
      lenHiQ     <= '0;
      txStatQ    <= '0;
      running    <= 1'b0;
      txStart    <= 1'b0;
      remRdStart <= 1'b0;
      remWrStart <= 1'b0;
    end else begin
      isrQ       <= isrNext;
      txStart    <= st.txGo;
      remRdStart <= st.remRdGo;
      remWrStart <= st.remWrGo;
      if (st.cmdWr)   cmdQ   <= regWdata;
      if (st.maskWr)  imrQ   <= regWdata;
      if (st.pageWr)  pageQ  <= regWdata;
      if (st.lenLoWr) lenLoQ <= regWdata;
      if (st.lenHiWr) lenHiQ <= regWdata;
      if (txDone) txStatQ <= {txLateColl, txHbLost, {(DW-3){1'b0}}, 1'b1};
      if (st.stopReq)       running <= 1'b0;
      else if (st.startReq) running <= 1'b1;
    end
  end

  assign irq         = |(isrQ & imrQ);
  assign txStartAddr = {pageQ, {PAGE_SHIFT{1'b0}}};
  assign txLen       = {lenHiQ, lenLoQ};

  always_comb begin
    case (regAddr)
      ADDR_W'(REG_CMD):   regRdata = cmdQ;
      ADDR_W'(REG_STAT):  regRdata = isrQ;
      ADDR_W'(REG_MASK):  regRdata = imrQ;
      ADDR_W'(REG_PAGE):  regRdata = pageQ;
      ADDR_W'(REG_LENLO): regRdata = lenLoQ;
      ADDR_W'(REG_LENHI): regRdata = lenHiQ;
      ADDR_W'(REG_TSTAT): regRdata = txStatQ;
      default:            regRdata = '0;
    endcase
  end

  AST_RST_ONLY_BY_START: assert property (@(posedge clk) disable iff (!rstN)
    $fell(isrQ[ST_RST]) |-> $past(st.startReq)); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (st.isrClr && (evtSet == '0) && !txDone && !dmaDone)
      |=> ((isrQ[DW-2:0] & $past(st.clrBits)) == '0)); // R3
  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    st.remZero |=> (isrQ[ST_RDC] && !remRdStart && !remWrStart)); // R4
  AST_REM_ONE_DIR: assert property (@(posedge clk) disable iff (!rstN)
    !(remRdStart && remWrStart)); // R5
  AST_TX_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    st.txGo |=> txStart); // R6
  AST_TX_DONE_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> (txStatQ[0] && isrQ[ST_PTX])); // R7
  AST_DMA_DONE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |=> isrQ[ST_RDC]); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (imrQ == '0) |-> !irq); // R9
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    st.stopReq |=> !running); // R10
endmodule

// File: rtl/nic_cmd_status.sv
module nic_cmd_status
  import nic_cmd_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int PAGE_SHIFT = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWe,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DW-1:0]            regWdata,
  output logic [DW-1:0]            regRdata,
  input  logic                     remCountZero,
  input  logic                     dmaDone,
  input  logic                     txDone,
  input  logic                     txHbLost,
  input  logic                     txLateColl,
  input  logic [DW-2:0]            evtSet,
  output logic                     irq,
  output logic                     running,
  output logic                     txStart,
  output logic [DW+PAGE_SHIFT-1:0] txStartAddr,
  output logic [2*DW-1:0]          txLen,
  output logic                     remRdStart,
  output logic                     remWrStart
);
  ctrlStrobes_t st;

  nic_cmd_decode #(.ADDR_W(ADDR_W)) decode_i (
    .regWe        (regWe),
    .regAddr      (regAddr),
    .regWdata     (regWdata),
    .remCountZero (remCountZero),
    .st           (st)
  );

  nic_cmd_regs #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) regs_i (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .dmaDone     (dmaDone),
    .txDone      (txDone),
    .txHbLost    (txHbLost),
    .txLateColl  (txLateColl),
    .evtSet      (evtSet),
    .regRdata    (regRdata),
    .irq         (irq),
    .running     (running),
    .txStart     (txStart),
    .txStartAddr (txStartAddr),
    .txLen       (txLen),
    .remRdStart  (remRdStart),
    .remWrStart  (remWrStart)
  );
endmodule

// File: tb/nic_cmd_status_tb_top.sv
module nic_cmd_status_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        remCountZero = 1'b0, dmaDone = 1'b0, txDone = 1'b0;
  logic        txHbLost = 1'b0, txLateColl = 1'b0;
  logic [6:0]  evtSet = '0;
  logic        irq, running, txStart, remRdStart, remWrStart;
  logic [15:0] txStartAddr, txLen;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] eCmd, eIsr, eImr, ePage, eLo, eHi, eTsr;
  logic       eRun, eTx, eRd, eWr;

  always #10 clk = ~clk;

  nic_cmd_status dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .remCountZero(remCountZero),
    .dmaDone(dmaDone), .txDone(txDone), .txHbLost(txHbLost),
    .txLateColl(txLateColl), .evtSet(evtSet), .irq(irq), .running(running),
    .txStart(txStart), .txStartAddr(txStartAddr), .txLen(txLen),
    .remRdStart(remRdStart), .remWrStart(remWrStart)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic expIrq();
    return |(eIsr & eImr);
  endfunction

  task automatic readChk(logic [3:0] a, logic [7:0] exp, string tag);
    regAddr = a;
    #1;
    check(tag, {8'h00, regRdata}, {8'h00, exp});
  endtask

  task automatic checkRegs(string pfx);
    readChk(4'd0, eCmd,  {pfx, " R11 cmd"});
    readChk(4'd1, eIsr,  {pfx, " R3 status"});
    readChk(4'd2, eImr,  {pfx, " R11 mask"});
    readChk(4'd3, ePage, {pfx, " R11 page"});
    readChk(4'd4, eLo,   {pfx, " R11 lenlo"});
    readChk(4'd5, eHi,   {pfx, " R11 lenhi"});
    readChk(4'd6, eTsr,  {pfx, " R7 tstat"});
    readChk(4'd7, 8'h00, {pfx, " R11 unmapped"});
  endtask

  task automatic checkOuts(string pfx);
    check({pfx, " R9 irq"},        {15'd0, irq},        {15'd0, expIrq()});
    check({pfx, " R10 running"},   {15'd0, running},    {15'd0, eRun});
    check({pfx, " R6 txStart"},    {15'd0, txStart},    {15'd0, eTx});
    check({pfx, " R5 remRd"},      {15'd0, remRdStart}, {15'd0, eRd});
    check({pfx, " R5 remWr"},      {15'd0, remWrStart}, {15'd0, eWr});
    check({pfx, " R6 txAddr"},     txStartAddr,         {ePage, 8'h00});
    check({pfx, " R6 txLen"},      txLen,               {eHi, eLo});
  endtask

  // one cycle of stimulus; called at a falling edge
  task automatic step(logic we, logic [3:0] a, logic [7:0] wd, logic zero,
                      logic dma, logic txd, logic hb, logic lc, logic [6:0] evt);
    logic startW, stopW, rdq, wrq;
    logic [7:0] n;
    regWe = we; regAddr = a; regWdata = wd; remCountZero = zero;
    dmaDone = dma; txDone = txd; txHbLost = hb; txLateColl = lc; evtSet = evt;
    startW = we && (a == 4'd0) && wd[1];
    stopW  = we && (a == 4'd0) && wd[0];
    rdq = startW && wd[3];
    wrq = startW && wd[4];
    n = eIsr;
    if (we && a == 4'd1) n[6:0] = n[6:0] & ~wd[6:0];
    if (startW) n[7] = 1'b0;
    n[6:0] = n[6:0] | evt;
    if (txd) n[1] = 1'b1;
    if (dma || ((rdq || wrq) && zero)) n[6] = 1'b1;
    eIsr = n;
    eTx = startW && wd[2];
    eRd = rdq && !wrq && !zero;
    eWr = wrq && !rdq && !zero;
    if (txd) eTsr = {lc, hb, 5'b0, 1'b1};
    if (we) begin
      case (a)
        4'd0: eCmd = wd;
        4'd2: eImr = wd;
        4'd3: ePage = wd;
        4'd4: eLo = wd;
        4'd5: eHi = wd;
        default: ;
      endcase
    end
    if (stopW) eRun = 1'b0;
    else if (startW) eRun = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0; dmaDone = 1'b0; txDone = 1'b0; evtSet = '0;
    txHbLost = 1'b0; txLateColl = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] wd, logic zero);
    step(1'b1, a, wd, zero, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    eCmd = 8'h01; eIsr = 8'h80; eImr = 0; ePage = 0; eLo = 0; eHi = 0;
    eTsr = 0; eRun = 0; eTx = 0; eRd = 0; eWr = 0;
    repeat (3) @(negedge clk);
    // R1: values held during reset
    readChk(4'd1, 8'h80, "R1 status in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkOuts("R1 reset");
    checkRegs("R1 reset");

    // R2: host clear cannot remove the reset flag
    wr(4'd1, 8'hFF, 1'b0);
    readChk(4'd1, 8'h80, "R2 w1c keeps bit7");
    wr(4'd2, 8'h80, 1'b0);
    checkOuts("R9 mask reset bit");
    wr(4'd0, 8'h02, 1'b0);
    readChk(4'd1, 8'h00, "R2 start clears bit7");
    checkOuts("R10 start");

    // R4: zero-length remote read
    wr(4'd2, 8'h40, 1'b0);
    wr(4'd0, 8'h0A, 1'b1);
    checkOuts("R4 zero len");
    readChk(4'd1, 8'h40, "R4 rdc set");
    // R5: remote write, then both directions
    wr(4'd0, 8'h12, 1'b0);
    checkOuts("R5 remote write");
    wr(4'd0, 8'h1A, 1'b0);
    checkOuts("R5 both dirs");

    // R6: transmit launch, then transmit without start
    wr(4'd3, 8'h40, 1'b0);
    wr(4'd4, 8'h3C, 1'b0);
    wr(4'd5, 8'h01, 1'b0);
    wr(4'd0, 8'h06, 1'b0);
    checkOuts("R6 tx launch");
    wr(4'd0, 8'h04, 1'b0);
    checkOuts("R6 tx no start");

    // R7: completion with heartbeat lost
    step(1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'd0);
    readChk(4'd6, 8'h41, "R7 tstat");
    readChk(4'd1, eIsr, "R7 ptx set");

    // R8 / R3: set wins over a same-cycle clear
    step(1'b1, 4'd1, 8'h7F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 7'h05);
    readChk(4'd1, 8'h45, "R3 set beats clear");
    wr(4'd1, 8'h44, 1'b0);
    readChk(4'd1, 8'h01, "R8 evt bit0 remains");

    // R11: transmit status is read-only
    wr(4'd6, 8'hAA, 1'b0);
    readChk(4'd6, 8'h41, "R11 tstat ro");

    // R10: stop wins over start
    wr(4'd0, 8'h03, 1'b0);
    checkOuts("R10 stop wins");
    checkRegs("directed");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic we;
      logic [3:0] a;
      logic [7:0] wd;
      we = ($urandom % 2) == 0;
      a  = 4'($urandom % 8);
      wd = 8'($urandom);
      if (a == 4'd0 && ($urandom % 2) == 0) wd[0] = 1'b0;
      step(we, a, wd, ($urandom % 3) == 0, ($urandom % 8) == 0,
           ($urandom % 8) == 0, 1'($urandom), 1'($urandom),
           (($urandom % 4) == 0) ? 7'($urandom) : 7'd0);
      checkOuts("rand");
      if ((i % 16) == 0) checkRegs("rand");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule